// File: doc/BRIEF.md
# Core Sleep and Lockup Controller

This block keeps track of the operating condition of a small processor core: running, in light sleep, in deep sleep, or locked up after an unrecoverable fault. It watches a handful of core-side strobes and levels and, one clock after the event that moves it, drives the clock and memory enables that the rest of the chip uses to stop the core, the system clock, the PLL and the flash. It also gives an enable that stops instruction execution, and it reports its current condition as a 2-bit code.

A wait-for-interrupt request puts the core to sleep. The depth of sleep is chosen by one select bit. The request does nothing if a wakeup is already pending. A fault raised while the NMI or HardFault handler runs cannot be taken as a new exception, so the core locks up. The controller remembers whether the NMI handler held the fault. A later NMI releases lockup only when the fault was not in the NMI handler. A debugger halt or a reset always releases lockup.

Top module: `core_power_ctrl`

## Requirements
- R1: With the state at run (00), `fault_stb` high while `hdlr_cls` is 01 (NMI) or 10 (HardFault) moves the state to lockup (11) on the next clock edge. This takes precedence over a wait-for-interrupt request in the same cycle.
- R2: With the state at run, `fault_stb` high while `hdlr_cls` is 00 (no handler) leaves the state at run.
- R3: In lockup, `exec_en` is 0 and `cpu_clk_en`, `sys_clk_en`, `pll_en` and `flash_en` stay 1.
- R4: In lockup, `halt_req` high returns the state to run on the next edge. This holds whichever handler held the fault.
- R5: In lockup entered with `hdlr_cls` = 10, `nmi_stb` returns the state to run on the next edge. In lockup entered with `hdlr_cls` = 01, `nmi_stb` is ignored and the state stays 11.
- R6: Asynchronous active-low `rst_n` forces state 00 with all five enables at 1. It also clears the record of NMI-origin lockup, so a later lockup from HardFault is released by NMI.
- R7: With the state at run, `wfi_req` high and `wake_pend` low moves the state on the next edge to 01 if `deep_sel` is 0, or to 10 if `deep_sel` is 1. If `wake_pend` is high, the state stays at run.
- R8: In light sleep (01), `cpu_clk_en` and `exec_en` are 0, and `sys_clk_en`, `pll_en` and `flash_en` are 1.
- R9: In deep sleep (10), `cpu_clk_en`, `sys_clk_en`, `pll_en`, `flash_en` and `exec_en` are all 0.
- R10: From either sleep state, `wake_pend`, `nmi_stb` or `halt_req` high returns the state to run, with all enables at 1, on the next edge.
- R11: In either sleep state, `fault_stb` and `wfi_req` have no effect: the state and the enables are unchanged.
- R12: In lockup, `wfi_req` and `wake_pend` have no effect: the state stays 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wfi_req | input | 1 | Wait-for-interrupt request |
| deep_sel | input | 1 | Sleep depth select: 0 light, 1 deep |
| wake_pend | input | 1 | Wakeup condition pending |
| fault_stb | input | 1 | Fault raised this cycle |
| hdlr_cls | input | HCLS_W (2) | Active handler: 00 none, 01 NMI, 10 HardFault |
| nmi_stb | input | 1 | NMI request |
| halt_req | input | 1 | Debugger halt request |
| cpu_clk_en | output | 1 | Processor clock enable |
| sys_clk_en | output | 1 | System clock enable |
| pll_en | output | 1 | PLL enable |
| flash_en | output | 1 | Flash enable |
| exec_en | output | 1 | Instruction execution enable |
| state_o | output | 2 | 00 run, 01 sleep, 10 deep sleep, 11 lockup |

## Verification
Two pairs of events can arrive in the same cycle. In the first, a fault is raised in a handler together with a wait-for-interrupt request. The bench drives both at once with `deep_sel` set, and it passes only if the state goes to 11 and not to 10. In the second, the core is locked up from the NMI handler while an NMI and a debugger halt arrive together. NMI alone must leave the state unchanged, so the bench first applies NMI by itself and checks that the state stays at lockup. It then applies NMI and halt together and expects run, which shows that the halt path is not blocked by the NMI-origin record.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'b00,
      ST_SLEEP = 2'b01,
      ST_DEEP  = 2'b10,
      ST_LOCK  = 2'b11
   } cpc_state_e;

   typedef struct packed {
      logic cpu_clk;
      logic sys_clk;
      logic pll;
      logic flash;
      logic exec;
   } cpc_en_t;

   localparam cpc_en_t CPC_EN_ALL = '{cpu_clk: 1'b1, sys_clk: 1'b1, pll: 1'b1,
                                      flash: 1'b1, exec: 1'b1};

endpackage

// File: rtl/cpc_next_state.sv
module cpc_next_state
   import cpc_pkg::*;
#(
   parameter int unsigned HCLS_W   = 2,
   parameter int unsigned NMI_CODE = 1,
   parameter int unsigned HF_CODE  = 2
) (
   input  cpc_state_e        cur_state,
   input  logic              cur_from_nmi,
   input  logic              wfi_req,
   input  logic              deep_sel,
   input  logic              wake_pend,
   input  logic              fault_stb,
   input  logic [HCLS_W-1:0] hdlr_cls,
   input  logic              nmi_stb,
   input  logic              halt_req,
   output cpc_state_e        nxt_state,
   output logic              nxt_from_nmi
);

   localparam logic [HCLS_W-1:0] CLS_NMI = HCLS_W'(NMI_CODE);
   localparam logic [HCLS_W-1:0] CLS_HF  = HCLS_W'(HF_CODE);

   logic in_nmi;
   logic in_hf;
   logic crit_fault;
   logic sleep_wake;
   logic lock_release;

   assign in_nmi       = (hdlr_cls == CLS_NMI);
   assign in_hf        = (hdlr_cls == CLS_HF);
   assign crit_fault   = fault_stb && (in_nmi || in_hf);
   assign sleep_wake   = wake_pend || nmi_stb || halt_req;
   assign lock_release = halt_req || (nmi_stb && !cur_from_nmi);

   always_comb begin
      nxt_state    = cur_state;
      nxt_from_nmi = cur_from_nmi;
      unique case (cur_state)
         ST_RUN: begin
            if (crit_fault) begin
               nxt_state    = ST_LOCK;
               nxt_from_nmi = in_nmi;
            end else if (wfi_req && !wake_pend) begin
               nxt_state = deep_sel ? ST_DEEP : ST_SLEEP;
            end
         end
         ST_SLEEP, ST_DEEP: begin
            if (sleep_wake) begin
               nxt_state = ST_RUN;
            end
         end
         ST_LOCK: begin
            if (lock_release) begin
               nxt_state    = ST_RUN;
               nxt_from_nmi = 1'b0;
            end
         end
         default: nxt_state = ST_RUN;
      endcase
   end

endmodule

// File: rtl/cpc_enable_decode.sv
module cpc_enable_decode
   import cpc_pkg::*;
(
   input  cpc_state_e st,
   output cpc_en_t    en
);

   always_comb begin
      en = CPC_EN_ALL;
      unique case (st)
         ST_RUN: en = CPC_EN_ALL;
         ST_SLEEP: begin
            en.cpu_clk = 1'b0;
            en.exec    = 1'b0;
         end
         ST_DEEP: begin
            en.cpu_clk = 1'b0;
            en.sys_clk = 1'b0;
            en.pll     = 1'b0;
            en.flash   = 1'b0;
            en.exec    = 1'b0;
         end
         ST_LOCK: en.exec = 1'b0;
         default: en = CPC_EN_ALL;
      endcase
   end

endmodule

// File: rtl/core_power_ctrl.sv
module core_power_ctrl
   import cpc_pkg::*;
#(
   parameter int unsigned HCLS_W      = 2,
   parameter int unsigned NMI_CODE    = 1,
   parameter int unsigned HF_CODE     = 2,
   parameter bit          REG_ENABLES = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wfi_req,
   input  logic              deep_sel,
   input  logic              wake_pend,
   input  logic              fault_stb,
   input  logic [HCLS_W-1:0] hdlr_cls,
   input  logic              nmi_stb,
   input  logic              halt_req,
   output logic              cpu_clk_en,
   output logic              sys_clk_en,
   output logic              pll_en,
   output logic              flash_en,
   output logic              exec_en,
   output logic [1:0]        state_o
);

   localparam int unsigned CLS_SPAN = 1 << HCLS_W;

   if (HCLS_W < 2) begin : g_bad_width
      $error("core_power_ctrl: HCLS_W must be at least 2");
   end
   if (NMI_CODE == 0 || HF_CODE == 0) begin : g_bad_zero
      $error("core_power_ctrl: handler code 0 is reserved for no handler");
   end
   if (NMI_CODE == HF_CODE) begin : g_bad_same
      $error("core_power_ctrl: NMI and HardFault codes must differ");
   end
   if (NMI_CODE >= CLS_SPAN || HF_CODE >= CLS_SPAN) begin : g_bad_range
      $error("core_power_ctrl: handler code does not fit HCLS_W");
   end

   cpc_state_e state_q;
   cpc_state_e state_d;
   logic       from_nmi_q;
   logic       from_nmi_d;
   cpc_en_t    en_out;

   cpc_next_state #(
      .HCLS_W   (HCLS_W),
      .NMI_CODE (NMI_CODE),
      .HF_CODE  (HF_CODE)
   ) u_next (
      .cur_state    (state_q),
      .cur_from_nmi (from_nmi_q),
      .wfi_req      (wfi_req),
      .deep_sel     (deep_sel),
      .wake_pend    (wake_pend),
      .fault_stb    (fault_stb),
      .hdlr_cls     (hdlr_cls),
      .nmi_stb      (nmi_stb),
      .halt_req     (halt_req),
      .nxt_state    (state_d),
      .nxt_from_nmi (from_nmi_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_RUN;
         from_nmi_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         from_nmi_q <= from_nmi_d;
      end
   end

   if (REG_ENABLES) begin : g_en_flop
      cpc_en_t en_d;
      cpc_en_t en_q;

      cpc_enable_decode u_dec (
         .st (state_d),
         .en (en_d)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q <= CPC_EN_ALL;
         end else begin
            en_q <= en_d;
         end
      end

      assign en_out = en_q;
   end else begin : g_en_comb
      cpc_enable_decode u_dec (
         .st (state_q),
         .en (en_out)
      );
   end

   assign cpu_clk_en = en_out.cpu_clk;
   assign sys_clk_en = en_out.sys_clk;
   assign pll_en     = en_out.pll;
   assign flash_en   = en_out.flash;
   assign exec_en    = en_out.exec;
   assign state_o    = state_q;

endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
   parameter int unsigned HCLS_W   = 2,
   parameter int unsigned NMI_CODE = 1,
   parameter int unsigned HF_CODE  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wfi_req,
   input logic              wake_pend,
   input logic              fault_stb,
   input logic [HCLS_W-1:0] hdlr_cls,
   input logic              nmi_stb,
   input logic              halt_req,
   input logic              from_nmi,
   input logic              cpu_clk_en,
   input logic              sys_clk_en,
   input logic              pll_en,
   input logic              flash_en,
   input logic              exec_en,
   input logic [1:0]        state_o
);

   localparam logic [HCLS_W-1:0] CLS_NMI = HCLS_W'(NMI_CODE);
   localparam logic [HCLS_W-1:0] CLS_HF  = HCLS_W'(HF_CODE);

   logic in_sleep;
   assign in_sleep = (state_o == 2'b01) || (state_o == 2'b10);

   p_fault_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b00 && fault_stb && (hdlr_cls == CLS_NMI || hdlr_cls == CLS_HF))
      |=> (state_o == 2'b11));

   p_plain_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b00 && fault_stb && hdlr_cls == '0 && !wfi_req) |=> (state_o == 2'b00));

   p_lock_exec_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b11) |-> (!exec_en && cpu_clk_en && sys_clk_en && pll_en && flash_en));

   p_halt_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b11 && halt_req) |=> (state_o == 2'b00));

   p_nmi_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b11 && from_nmi && !halt_req) |=> (state_o == 2'b11));

   p_wfi_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b00 && wfi_req && wake_pend && !fault_stb) |=> (state_o == 2'b00));

   p_light_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b01) |-> (!cpu_clk_en && !exec_en && sys_clk_en && pll_en && flash_en));

   p_deep_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b10) |-> (!cpu_clk_en && !sys_clk_en && !pll_en && !flash_en && !exec_en));

   p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sleep && (wake_pend || nmi_stb || halt_req))
      |=> (state_o == 2'b00 && cpu_clk_en && sys_clk_en && pll_en && flash_en && exec_en));

   p_sleep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sleep && !wake_pend && !nmi_stb && !halt_req) |=> $stable(state_o));

   p_lock_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b11 && !halt_req && !nmi_stb) |=> (state_o == 2'b11));

endmodule

bind core_power_ctrl cpc_checker #(
   .HCLS_W   (HCLS_W),
   .NMI_CODE (NMI_CODE),
   .HF_CODE  (HF_CODE)
) u_cpc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .wfi_req    (wfi_req),
   .wake_pend  (wake_pend),
   .fault_stb  (fault_stb),
   .hdlr_cls   (hdlr_cls),
   .nmi_stb    (nmi_stb),
   .halt_req   (halt_req),
   .from_nmi   (from_nmi_q),
   .cpu_clk_en (cpu_clk_en),
   .sys_clk_en (sys_clk_en),
   .pll_en     (pll_en),
   .flash_en   (flash_en),
   .exec_en    (exec_en),
   .state_o    (state_o)
);

// File: tb/core_power_ctrl_bench.sv
`timescale 1ns/1ps
module core_power_ctrl_bench;

   localparam logic [6:0] V_RUN   = {2'b00, 5'b11111};
   localparam logic [6:0] V_SLEEP = {2'b01, 5'b01110};
   localparam logic [6:0] V_DEEP  = {2'b10, 5'b00000};
   localparam logic [6:0] V_LOCK  = {2'b11, 5'b11110};

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wfi_req, deep_sel, wake_pend, fault_stb, nmi_stb, halt_req;
   logic [1:0] hdlr_cls;
   logic       cpu_clk_en, sys_clk_en, pll_en, flash_en, exec_en;
   logic [1:0] state_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   core_power_ctrl u_core_power_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wfi_req    (wfi_req),
      .deep_sel   (deep_sel),
      .wake_pend  (wake_pend),
      .fault_stb  (fault_stb),
      .hdlr_cls   (hdlr_cls),
      .nmi_stb    (nmi_stb),
      .halt_req   (halt_req),
      .cpu_clk_en (cpu_clk_en),
      .sys_clk_en (sys_clk_en),
      .pll_en     (pll_en),
      .flash_en   (flash_en),
      .exec_en    (exec_en),
      .state_o    (state_o)
   );

   function automatic logic [6:0] observed();
      return {state_o, cpu_clk_en, sys_clk_en, pll_en, flash_en, exec_en};
   endfunction

   task automatic check(input string req, input logic [6:0] exp);
      logic [6:0] got;
      got = observed();
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got state/en=%b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic idle();
      wfi_req = 0; deep_sel = 0; wake_pend = 0; fault_stb = 0;
      nmi_stb = 0; halt_req = 0; hdlr_cls = 2'b00;
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      idle();
      rst_n = 1'b0;
      #3;
      check("R6 reset asserted", V_RUN);
      tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_light_sleep();
      wfi_req = 1; deep_sel = 0;
      tick(); idle();
      check("R7 R8 light sleep entry", V_SLEEP);
      fault_stb = 1; hdlr_cls = 2'b10; wfi_req = 1; deep_sel = 1;
      tick(); idle();
      check("R11 fault and wfi ignored in sleep", V_SLEEP);
      wake_pend = 1;
      tick(); idle();
      check("R10 wake_pend exits sleep", V_RUN);
   endtask

   task automatic t_deep_sleep();
      wfi_req = 1; deep_sel = 1;
      tick(); idle();
      check("R7 R9 deep sleep entry", V_DEEP);
      tick();
      check("R11 deep sleep holds", V_DEEP);
      nmi_stb = 1;
      tick(); idle();
      check("R10 NMI exits deep sleep", V_RUN);
      wfi_req = 1; deep_sel = 1;
      tick(); idle();
      halt_req = 1;
      tick(); idle();
      check("R10 halt exits deep sleep", V_RUN);
   endtask

   task automatic t_wfi_pending();
      wfi_req = 1; deep_sel = 1; wake_pend = 1;
      tick(); idle();
      check("R7 wfi with wake pending stays run", V_RUN);
   endtask

   task automatic t_plain_fault();
      fault_stb = 1; hdlr_cls = 2'b00;
      tick(); idle();
      check("R2 fault outside handler", V_RUN);
   endtask

   task automatic t_lock_hf();
      fault_stb = 1; hdlr_cls = 2'b10;
      tick(); idle();
      check("R1 R3 HardFault lockup", V_LOCK);
      wfi_req = 1; wake_pend = 1;
      tick(); idle();
      check("R12 wfi and wake ignored in lockup", V_LOCK);
      nmi_stb = 1;
      tick(); idle();
      check("R5 NMI exits HardFault lockup", V_RUN);
      fault_stb = 1; hdlr_cls = 2'b10;
      tick(); idle();
      halt_req = 1;
      tick(); idle();
      check("R4 halt exits HardFault lockup", V_RUN);
   endtask

   task automatic t_lock_nmi();
      fault_stb = 1; hdlr_cls = 2'b01;
      tick(); idle();
      check("R1 NMI-handler lockup", V_LOCK);
      nmi_stb = 1;
      tick(); idle();
      check("R5 NMI ignored after NMI-handler lockup", V_LOCK);
      nmi_stb = 1; halt_req = 1;
      tick(); idle();
      check("R4 halt with NMI exits lockup", V_RUN);
   endtask

   task automatic t_fault_with_wfi();
      fault_stb = 1; hdlr_cls = 2'b01; wfi_req = 1; deep_sel = 1;
      tick(); idle();
      check("R1 fault beats wfi", V_LOCK);
      nmi_stb = 1;
      tick(); idle();
      check("R5 NMI still ignored", V_LOCK);
      do_reset();
      check("R6 reset leaves lockup", V_RUN);
      fault_stb = 1; hdlr_cls = 2'b10;
      tick(); idle();
      nmi_stb = 1;
      tick(); idle();
      check("R6 reset cleared NMI-origin record", V_RUN);
   endtask

   initial begin
      idle();
      rst_n = 1'b0;
      #3;
      check("R6 reset state", V_RUN);
      tick();
      rst_n = 1'b1;
      tick();
      check("R6 run after reset release", V_RUN);
      t_light_sleep();
      t_deep_sleep();
      t_wfi_pending();
      t_plain_fault();
      t_lock_hf();
      t_lock_nmi();
      t_fault_with_wfi();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got running expected finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule